// File: doc/BRIEF.md
# Seven-Level Carrier PWM Gate Generator

This block drives the eight gate switches of a single-phase, seven-level switched-capacitor inverter that has a common ground. A free-running up/down counter produces one triangular carrier. Three level-shifted copies of it divide the reference magnitude range into bands. The reference is a sampled sine taken from a 16-entry quarter-wave table and scaled by a programmable modulation index. The sine's phase advances by a programmable step once per carrier period.

Each clock, the block counts how many shifted carriers lie below the reference magnitude. It gives that count the sign of the current half-cycle to form a signed level from −3 to +3. It then decodes the level into a switch pattern. Every gate turn-on passes through a dead-time delay, so that paired switches never overlap. A controller sets the index, the carrier half-period, the phase step and the dead time, and the gate outputs go to isolated drivers.

Top module: `sevenlevel_pwm`

## Requirements
- R1: While reset is low, and during the first clocks after its release, all eight gates are low and the level output is 0.
- R2: The carrier counts 0,1,…,P and then P−1,…,1, for a period of 2P clocks, where P is the carrier half-period input (values below 4 are taken as 4). The reference is resampled when the count is 0 while rising, and the phase then advances by the step input.
- R3: The phase is 16 bits. Bits 15:14 give the quadrant, and bits 13:10 give the table index i. The table holds round(1023·sin((i+0.5)·π/32)). The index is mirrored (15−i) in quadrants 1 and 3, and quadrants 2 and 3 are the negative half. The magnitude is mag = ((sine·MI)>>10 · 3P)>>10, with MI a 10-bit index in units of 1/1024.
- R4: The level is a 3-bit two's-complement code. Its magnitude is the number of the thresholds c, c+P and c+2P (c being the carrier) that are strictly below mag, and its sign is that of the half-cycle. It is registered one clock after the carrier value it uses.
- R5: Gate bit k drives switch S(k+1). Once demand has settled, the patterns are: +3 → S1,S5,S6; +2 → S2,S3,S5,S6; +1 → S4,S5,S6; 0 in the positive half → S4,S6,S8; 0 in the negative half → S1,S5,S7; −1 → S2,S3,S7,S8; −2 → S4,S7,S8; −3 → S3,S7,S8.
- R6: S1 and S2, S3 and S4, S5 and S8, and S6 and S7 are never on together.
- R7: S6 is on only in the positive half-cycle and S7 only in the negative one, so both change only when the half-cycle changes.
- R8: A gate turns on dt+1 clocks after its demand rises and turns off one clock after its demand falls. Dead-time values below 2 are taken as 2.
- R9: With MI = 614 (about 0.6) the top band is never reached, so the level stays within ±2 while still reaching ±2.
- R10: With MI = 0 the level is always 0 and the gates sit in the zero pattern of the current half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_index | input | 10 | Modulation index, unsigned, in units of 1/1024 |
| car_period | input | 12 | Carrier half-period P in clocks |
| ref_step | input | 16 | Phase increment applied per carrier period |
| dead_time | input | 6 | Turn-on delay count (minimum 2) |
| gate_o | output | 8 | Gate drives, bit k is S(k+1) |
| level_o | output | 3 | Signed output level code |

## Verification
A change of half-cycle can coincide with a level change. In that cycle S6 and S7 swap while S5 and S8 are also handing over, so four dead-time counters run at once. A sweep with full index and a fast phase step crosses zero many times and provokes this. The result is judged every cycle by an interlock monitor, and on each settled level by comparing the gates with the expected pattern. A fixed reference with a phase step of half a turn also flips the half-cycle at every period while the level stays 0, which isolates the S6/S7 handover.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int LUT_W   = 10;
  localparam int LUT_IDX = 4;
  localparam int N_BAND  = 3;
  localparam int N_GATE  = 8;
  localparam int CAR_MIN = 4;
  localparam int DT_MIN  = 2;

  typedef logic signed [2:0] level_t;

  // Quarter-wave sine samples, taken at the centre of each index step
  function automatic logic [LUT_W-1:0] qsine(input logic [LUT_IDX-1:0] i);
    case (i)
      4'd0:  qsine = 10'd50;
      4'd1:  qsine = 10'd150;
      4'd2:  qsine = 10'd249;
      4'd3:  qsine = 10'd345;
      4'd4:  qsine = 10'd437;
      4'd5:  qsine = 10'd526;
      4'd6:  qsine = 10'd609;
      4'd7:  qsine = 10'd687;
      4'd8:  qsine = 10'd758;
      4'd9:  qsine = 10'd822;
      4'd10: qsine = 10'd877;
      4'd11: qsine = 10'd925;
      4'd12: qsine = 10'd963;
      4'd13: qsine = 10'd992;
      4'd14: qsine = 10'd1012;
      default: qsine = 10'd1022;
    endcase
  endfunction
endpackage

// File: rtl/sl_carrier.sv
module sl_carrier #(
  parameter int CAR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAR_W-1:0] period_in,
  output logic [CAR_W-1:0] carrier,
  output logic [CAR_W-1:0] period_eff,
  output logic             per_start
);
  import sl_pkg::*;

  logic [CAR_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  assign period_eff = (period_in < CAR_W'(CAR_MIN)) ? CAR_W'(CAR_MIN) : period_in;
  assign carrier    = cnt_q;
  assign per_start  = up_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (up_q) begin
      if (cnt_q >= period_eff) begin
        up_d  = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= CAR_W'(1)) begin
        up_d  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/sl_reference.sv
module sl_reference #(
  parameter int PH_W  = 16,
  parameter int MI_W  = 10,
  parameter int CAR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PH_W-1:0]    step,
  input  logic [MI_W-1:0]    mod_index,
  input  logic [CAR_W-1:0]   period,
  output logic [CAR_W+1:0]   mag,
  output logic               neg
);
  import sl_pkg::*;

  localparam int MAG_W = CAR_W + 2;
  localparam int P1_W  = LUT_W + MI_W;
  localparam int P2_W  = LUT_W + MAG_W;

  logic [PH_W-1:0]    phase_q, phase_d;
  logic [MAG_W-1:0]   mag_q, mag_d;
  logic               neg_q, neg_d;
  logic [1:0]         quad;
  logic [LUT_IDX-1:0] idx, addr;
  logic [LUT_W-1:0]   sine;
  logic [P1_W-1:0]    prod1;
  logic [LUT_W-1:0]   scaled;
  logic [MAG_W-1:0]   span;
  logic [P2_W-1:0]    prod2;

  assign quad   = phase_q[PH_W-1 -: 2];
  assign idx    = phase_q[PH_W-3 -: LUT_IDX];
  assign addr   = quad[0] ? ~idx : idx;
  assign sine   = qsine(addr);
  assign prod1  = P1_W'(sine) * P1_W'(mod_index);
  assign scaled = prod1[MI_W +: LUT_W];
  assign span   = {2'b00, period} + {1'b0, period, 1'b0};
  assign prod2  = P2_W'(scaled) * P2_W'(span);

  always_comb begin
    phase_d = phase_q;
    mag_d   = mag_q;
    neg_d   = neg_q;
    if (load) begin
      phase_d = phase_q + step;
      mag_d   = prod2[LUT_W +: MAG_W];
      neg_d   = quad[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mag_q   <= mag_d;
      neg_q   <= neg_d;
    end
  end

  assign mag = mag_q;
  assign neg = neg_q;
endmodule

// File: rtl/sl_level.sv
module sl_level #(
  parameter int CAR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_start,
  input  logic [CAR_W-1:0] carrier,
  input  logic [CAR_W-1:0] period,
  input  logic [CAR_W+1:0] mag,
  input  logic             neg,
  output logic [2:0]       level,
  output logic             half_neg,
  output logic             run
);
  import sl_pkg::*;

  localparam int MAG_W = CAR_W + 2;

  logic [N_BAND-1:0] cmd;
  logic [1:0]        count;
  logic [2:0]        level_q, level_d;
  logic              half_q, half_d;
  logic              run_q, run_d;

  // One comparator per level-shifted carrier, lowest band first
  for (genvar j = 0; j < N_BAND; j++) begin : g_band
    logic [MAG_W-1:0] thr;
    assign thr    = MAG_W'(carrier) + MAG_W'(j) * MAG_W'(period);
    assign cmd[j] = mag > thr;
  end

  assign count = 2'(cmd[0]) + 2'(cmd[1]) + 2'(cmd[2]);

  always_comb begin
    run_d   = run_q | per_start;
    level_d = 3'b000;
    half_d  = 1'b0;
    if (run_q) begin
      half_d  = neg;
      level_d = neg ? (3'b000 - {1'b0, count}) : {1'b0, count};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 3'b000;
      half_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      half_q  <= half_d;
      run_q   <= run_d;
    end
  end

  assign level    = level_q;
  assign half_neg = half_q;
  assign run      = run_q;
endmodule

// File: rtl/sl_gate_decode.sv
module sl_gate_decode (
  input  logic [2:0] level,
  input  logic       half_neg,
  output logic [7:0] want
);
  // want[k] demands switch S(k+1)
  always_comb begin
    want = 8'b0;
    case (level)
      3'd3: begin want[0] = 1'b1; want[4] = 1'b1; want[5] = 1'b1; end
      3'd2: begin want[1] = 1'b1; want[2] = 1'b1; want[4] = 1'b1; want[5] = 1'b1; end
      3'd1: begin want[3] = 1'b1; want[4] = 1'b1; want[5] = 1'b1; end
      3'd0: begin
        if (half_neg) begin
          want[0] = 1'b1; want[4] = 1'b1; want[6] = 1'b1;
        end else begin
          want[3] = 1'b1; want[5] = 1'b1; want[7] = 1'b1;
        end
      end
      3'b111: begin want[1] = 1'b1; want[2] = 1'b1; want[6] = 1'b1; want[7] = 1'b1; end
      3'b110: begin want[3] = 1'b1; want[6] = 1'b1; want[7] = 1'b1; end
      3'b101: begin want[2] = 1'b1; want[6] = 1'b1; want[7] = 1'b1; end
      default: want = 8'b0;
    endcase
  end
endmodule

// File: rtl/sl_deadtime.sv
module sl_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            want,
  input  logic [DT_W-1:0] dt,
  output logic            gate
);
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            g_q, g_d;

  always_comb begin
    cnt_d = cnt_q;
    g_d   = g_q;
    if (!run || !want) begin
      cnt_d = '0;
      g_d   = 1'b0;
    end else if (!g_q) begin
      if (cnt_q >= dt) g_d = 1'b1;
      else             cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      g_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      g_q   <= g_d;
    end
  end

  assign gate = g_q;
endmodule

// File: rtl/sevenlevel_pwm.sv
module sevenlevel_pwm #(
  parameter int CAR_W = 12,
  parameter int PH_W  = 16,
  parameter int MI_W  = 10,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MI_W-1:0]  mod_index,
  input  logic [CAR_W-1:0] car_period,
  input  logic [PH_W-1:0]  ref_step,
  input  logic [DT_W-1:0]  dead_time,
  output logic [7:0]       gate_o,
  output logic [2:0]       level_o
);
  import sl_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [CAR_W-1:0] carrier, period_eff;
  logic             per_start;
  logic [CAR_W+1:0] mag;
  logic             ref_neg, half_neg, run;
  logic [2:0]       level;
  logic [7:0]       gate_want;
  logic [DT_W-1:0]  dt_eff;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i  = rst_sync_q[1];
  assign dt_eff = (dead_time < DT_W'(DT_MIN)) ? DT_W'(DT_MIN) : dead_time;

  sl_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_i), .period_in(car_period),
    .carrier(carrier), .period_eff(period_eff), .per_start(per_start)
  );

  sl_reference #(.PH_W(PH_W), .MI_W(MI_W), .CAR_W(CAR_W)) u_ref (
    .clk(clk), .rst_n(rst_i), .load(per_start), .step(ref_step),
    .mod_index(mod_index), .period(period_eff), .mag(mag), .neg(ref_neg)
  );

  sl_level #(.CAR_W(CAR_W)) u_lvl (
    .clk(clk), .rst_n(rst_i), .per_start(per_start), .carrier(carrier),
    .period(period_eff), .mag(mag), .neg(ref_neg),
    .level(level), .half_neg(half_neg), .run(run)
  );

  sl_gate_decode u_dec (.level(level), .half_neg(half_neg), .want(gate_want));

  for (genvar k = 0; k < N_GATE; k++) begin : g_dt
    sl_deadtime #(.DT_W(DT_W)) u_dt (
      .clk(clk), .rst_n(rst_i), .run(run), .want(gate_want[k]),
      .dt(dt_eff), .gate(gate_o[k])
    );
  end

  assign level_o = level;
endmodule

// File: rtl/sevenlevel_pwm_chk.sv
module sevenlevel_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] gate,
  input logic [2:0] level,
  input logic [7:0] want
);
  p_reset_gates_r1: assert property (@(posedge clk) !rst_n |-> gate == 8'h00);

  p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level != 3'b100);

  p_s1s2_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(gate[0] && gate[1]));
  p_s3s4_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(gate[2] && gate[3]));
  p_s5s8_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(gate[4] && gate[7]));
  p_s6s7_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(gate[5] && gate[6]));

  p_s6_off_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level[2] && $past(level[2])) |-> !gate[5]);
  p_s7_off_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!level[2] && level != 3'b000) && (!$past(level[2]) && $past(level) != 3'b000)) |-> !gate[6]);

  for (genvar k = 0; k < 8; k++) begin : g_on
    p_turnon_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[k]) |-> ($past(want[k]) && $past(want[k], 2)));
  end
endmodule

bind sevenlevel_pwm sevenlevel_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate_o), .level(level_o), .want(gate_want)
);

// File: tb/sevenlevel_pwm_bench.sv
module sevenlevel_pwm_bench;
  logic        clk;
  logic        rst_n;
  logic [9:0]  mod_index;
  logic [11:0] car_period;
  logic [15:0] ref_step;
  logic [5:0]  dead_time;
  logic [7:0]  gate_o;
  logic [2:0]  level_o;

  int n_chk = 0;
  int n_fail = 0;
  int il_viol = 0;
  int cycles = 0;
  bit done = 0;

  sevenlevel_pwm u_sevenlevel_pwm (
    .clk(clk), .rst_n(rst_n), .mod_index(mod_index), .car_period(car_period),
    .ref_step(ref_step), .dead_time(dead_time), .gate_o(gate_o), .level_o(level_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // R6 monitor: paired switches, sampled away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ((gate_o[0] && gate_o[1]) || (gate_o[2] && gate_o[3]) ||
          (gate_o[4] && gate_o[7]) || (gate_o[5] && gate_o[6]))
        il_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_gates(input logic signed [2:0] lv);
    case (lv)
      3'sd3:  exp_gates = 8'h31;
      3'sd2:  exp_gates = 8'h36;
      3'sd1:  exp_gates = 8'h38;
      -3'sd1: exp_gates = 8'hC6;
      -3'sd2: exp_gates = 8'hC8;
      -3'sd3: exp_gates = 8'hC4;
      default: exp_gates = 8'h00;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    mod_index = 10'd1023; car_period = 12'd100; ref_step = 16'd0; dead_time = 6'd4;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate_o == 8'h00, "R1", "gates in reset", gate_o, 0);
    chk(level_o == 3'd0, "R1", "level in reset", level_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(gate_o == 8'h00, "R1", "gates just after release", gate_o, 0);
  endtask

  task automatic t_zero_index();
    int bad;
    bit s6_seen, s7_seen;
    mod_index = 10'd0; ref_step = 16'd0; dead_time = 6'd3;
    do_reset();
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (level_o != 3'd0) bad++;
    end
    chk(bad == 0, "R10", "nonzero level at index 0", bad, 0);
    chk(gate_o == 8'hA8, "R10", "positive zero pattern", gate_o, 8'hA8);
    ref_step = 16'h8000;
    bad = 0; s6_seen = 0; s7_seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (level_o != 3'd0) bad++;
      if (gate_o == 8'h51) s7_seen = 1;
      if (gate_o == 8'hA8) s6_seen = 1;
    end
    chk(bad == 0, "R10", "nonzero level with flipping half", bad, 0);
    chk(s6_seen && s7_seen, "R7", "both zero patterns seen", {s6_seen, s7_seen}, 3);
  endtask

  task automatic t_fixed_ref();
    int ones, other, a, b, d;
    mod_index = 10'd1023; car_period = 12'd100; ref_step = 16'd0; dead_time = 6'd4;
    do_reset();
    repeat (400) @(negedge clk);
    ones = 0; other = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (level_o == 3'd1) ones++;
      else if (level_o != 3'd0) other++;
    end
    // mag = ((50*1023)>>10 * 300)>>10 = 14 -> carrier 0..13 twice minus one
    chk(ones == 27, "R3", "level-1 cycles per period", ones, 27);
    chk(other == 0, "R4", "levels outside 0/1", other, 0);
    // R2: period from S5 rise to rise
    while (gate_o[4]) @(negedge clk);
    while (!gate_o[4]) @(negedge clk);
    a = cycles;
    while (gate_o[4]) @(negedge clk);
    while (!gate_o[4]) @(negedge clk);
    b = cycles;
    chk(b - a == 200, "R2", "carrier period", b - a, 200);
    // R8: dead time
    while (level_o != 3'd0) @(negedge clk);
    while (level_o != 3'd1) @(negedge clk);
    chk(gate_o[7] && !gate_o[4], "R8", "S8 on S5 off at level change", gate_o, 8'h80);
    d = 0;
    @(negedge clk); d++;
    chk(!gate_o[7] && !gate_o[4], "R8", "dead band both off", gate_o, 0);
    while (!gate_o[4] && d < 50) begin @(negedge clk); d++; end
    chk(d == 5, "R8", "turn-on delay dt=4", d, 5);
    mod_index = 10'd512;
    repeat (400) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (level_o == 3'd1) ones++;
    end
    // mag = ((50*512)>>10 * 300)>>10 = 7
    chk(ones == 13, "R3", "level-1 cycles at half index", ones, 13);
  endtask

  task automatic t_dt_clamp();
    int d;
    mod_index = 10'd1023; car_period = 12'd100; ref_step = 16'd0; dead_time = 6'd0;
    do_reset();
    repeat (400) @(negedge clk);
    while (level_o != 3'd0) @(negedge clk);
    while (level_o != 3'd1) @(negedge clk);
    d = 0;
    while (!gate_o[4] && d < 50) begin @(negedge clk); d++; end
    chk(d == 3, "R8", "turn-on delay clamped to 2", d, 3);
  endtask

  task automatic t_sweep();
    int bad, stable, s6r;
    bit [6:0] seen;
    logic signed [2:0] lv, prev;
    logic p6;
    mod_index = 10'd1023; car_period = 12'd100; ref_step = 16'd1638; dead_time = 6'd3;
    do_reset();
    bad = 0; stable = 0; s6r = 0; seen = '0; prev = 3'sd0; p6 = 1'b0;
    for (int i = 0; i < 17000; i++) begin
      @(negedge clk);
      lv = $signed(level_o);
      if (lv == prev) stable++; else stable = 1;
      prev = lv;
      seen[int'(lv) + 3] = 1'b1;
      if (lv != 3'sd0 && stable >= 6 && gate_o != exp_gates(lv)) begin
        if (bad == 0)
          $display("FAIL R5 gate pattern level=%0d actual=%0h expected=%0h",
                   lv, gate_o, exp_gates(lv));
        bad++;
      end
      if (gate_o[5] && !p6) s6r++;
      p6 = gate_o[5];
    end
    chk(seen == 7'h7F, "R4", "all seven levels seen", seen, 7'h7F);
    chk(bad == 0, "R5", "settled gate patterns", bad, 0);
    chk(s6r >= 1 && s6r <= 3, "R7", "S6 rises over two fundamentals", s6r, 2);
  endtask

  task automatic t_five_level();
    int big;
    bit p2, n2;
    mod_index = 10'd614; car_period = 12'd100; ref_step = 16'd1638; dead_time = 6'd3;
    do_reset();
    big = 0; p2 = 0; n2 = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (level_o == 3'd3 || level_o == 3'b101) big++;
      if (level_o == 3'd2) p2 = 1;
      if (level_o == 3'b110) n2 = 1;
    end
    chk(big == 0, "R9", "level 3 reached at index 0.6", big, 0);
    chk(p2 && n2, "R9", "both +2 and -2 reached", {p2, n2}, 3);
  endtask

  initial begin
    rst_n = 1'b0;
    mod_index = '0; car_period = 12'd100; ref_step = '0; dead_time = 6'd4;
    t_reset();
    t_zero_index();
    t_fixed_ref();
    t_dt_clamp();
    t_sweep();
    t_five_level();
    chk(il_viol == 0, "R6", "paired switch overlap count", il_viol, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule